// File: doc/BRIEF.md
# Segmented Instruction Pointer Unit

This unit keeps the code segment and the instruction offset of a 16-bit processor core and turns them into a 20-bit physical fetch address. The segment is moved up by four bit positions and the offset is added. A sum that runs past 20 bits wraps around. One control operation is taken per accepted request: a sequential step, a near or far jump, a near or far call or return, a software interrupt, an interrupt return, or an attempted register move into the code segment. The move is refused and reported as an invalid-opcode event.

Calls, returns and interrupts save or restore state through a word-wide stack port and read new targets through an interrupt-vector-table read port. Both ports use request/acknowledge handshakes. Each step of such a sequence waits for its acknowledge before the next step starts, and the unit reports busy for the whole sequence. Instruction decoding, stack pointer arithmetic, the flags register and memory all sit outside the unit.

Top module: `seg_ip_unit`

## Requirements
- R1: `fetch_addr` equals `cs_out*16 + ip_out` reduced modulo 2^20. For example, 0x1234:0x5678 gives 0x179B8 and 0xFFFF:0xFFFF gives 0x0FFEF.
- R2: Op code 1 (step) adds `instr_len` to the offset modulo 2^16 and leaves the segment unchanged. The new value is visible in the cycle after the accepting edge.
- R3: Op code 2 (near jump) loads `tgt_ip` into the offset and leaves the segment unchanged.
- R4: Op code 3 (far jump) loads `tgt_cs` and `tgt_ip` together at a single edge.
- R5: Op code 4 (near call) pushes offset+`instr_len` as one word and then loads `tgt_ip`. Op code 5 (near return) pops one word into the offset. Neither changes the segment.
- R6: Op code 6 (far call) pushes the segment and then offset+`instr_len`, and only then loads `tgt_cs`:`tgt_ip`. Op code 7 (far return) pops the offset first and the segment second.
- R7: Op code 8 (software interrupt) pushes `flags_in`, then the segment, then offset+`instr_len`. It then reads byte address 4*`int_num` as the new offset and 4*`int_num`+2 as the new segment.
- R8: Op code 9 (interrupt return) pops the offset, then the segment, then a flags word. The flags word appears on `flags_data` with `flags_valid` high in the cycle its pop is acknowledged.
- R9: Op code 10 (register move into the code segment) leaves the segment and the offset unchanged. It raises `invalid_op` for exactly the one cycle after the accepting edge.
- R10: `busy` is high from the edge that accepts op codes 4 to 9 until the edge that takes their last acknowledge. Any `op_valid` seen while `busy` is high has no effect.
- R11: A stack request holds `stk_req`, `stk_write` (1 for push, 0 for pop) and `stk_wdata` stable until `stk_ack` is sampled high. A vector request holds `ivt_req` and `ivt_addr` stable until `ivt_ack` is sampled high. The two requests are never raised together.
- R12: After reset the segment is 0xFFFF, the offset is 0x0000, the fetch address is 0xFFFF0, and `busy` and `invalid_op` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation request, taken when not busy |
| op_code | input | 4 | Operation selector (codes in R2 to R10) |
| instr_len | input | 4 | Byte length of the current instruction |
| tgt_ip | input | 16 | Target offset for jumps and calls |
| tgt_cs | input | 16 | Target segment for far jumps and calls |
| int_num | input | 8 | Software interrupt number |
| flags_in | input | 16 | Flags word saved by a software interrupt |
| stk_req | output | 1 | Stack access request |
| stk_write | output | 1 | 1 = push, 0 = pop |
| stk_wdata | output | 16 | Word to push |
| stk_ack | input | 1 | Stack access acknowledge |
| stk_rdata | input | 16 | Popped word, valid with acknowledge |
| ivt_req | output | 1 | Vector table read request |
| ivt_addr | output | 20 | Byte address of the vector word |
| ivt_ack | input | 1 | Vector read acknowledge |
| ivt_rdata | input | 16 | Vector word, valid with acknowledge |
| cs_out | output | 16 | Current code segment |
| ip_out | output | 16 | Current instruction offset |
| fetch_addr | output | 20 | Physical fetch address |
| busy | output | 1 | Multi-step sequence in progress |
| invalid_op | output | 1 | Invalid-opcode pulse |
| flags_valid | output | 1 | Restored flags word present |
| flags_data | output | 16 | Restored flags word |

## Verification
The bench drives the address sum past bit 19 and the offset past 0xFFFF. A design that kept the carry, or widened the offset, would point the fetch outside the 1 MiB space instead of wrapping back near zero.

It checks the order of every push and pop, and the two vector word addresses. Swapping segment and offset on the stack would send a far return or an interrupt return to a scrambled location. Reading the vector halves the wrong way round would do the same for the interrupt target.

A request for a far jump is held up during a slow far call. A unit that listened while busy would end at the bogus target. The refused segment move must leave the registers alone and must pulse the exception for one cycle only.

// File: rtl/seg_ip_pkg.sv
package seg_ip_pkg;

  localparam int WORD_W    = 16;
  localparam int SEG_SHIFT = 4;
  localparam int PA_W      = WORD_W + SEG_SHIFT;
  localparam int VEC_W     = 8;
  localparam int LEN_W     = 4;
  localparam int OP_W      = 4;

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [PA_W-1:0]   paddr_t;

  typedef enum logic [OP_W-1:0] {
    OP_NOP    = 4'd0,
    OP_STEP   = 4'd1,
    OP_JMP_N  = 4'd2,
    OP_JMP_F  = 4'd3,
    OP_CALL_N = 4'd4,
    OP_RET_N  = 4'd5,
    OP_CALL_F = 4'd6,
    OP_RET_F  = 4'd7,
    OP_SWI    = 4'd8,
    OP_IRET   = 4'd9,
    OP_MOV_CS = 4'd10
  } op_e;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_PUSH_FLG,
    ST_PUSH_CS,
    ST_PUSH_IP,
    ST_VEC_IP,
    ST_VEC_CS,
    ST_POP_IP,
    ST_POP_CS,
    ST_POP_FLG
  } step_e;

  typedef struct packed {
    logic  cs_we;
    logic  ip_we;
    word_t cs_val;
    word_t ip_val;
  } commit_t;

  // Segment moved up by SEG_SHIFT plus offset; carry past PA_W is dropped.
  function automatic paddr_t phys_addr(input word_t seg, input word_t off);
    phys_addr = (paddr_t'(seg) << SEG_SHIFT) + paddr_t'(off);
  endfunction

  // Vector entry n occupies four bytes: offset word low, segment word high.
  function automatic paddr_t vec_addr(input logic [VEC_W-1:0] num, input logic hi);
    vec_addr = paddr_t'({num, hi, 1'b0});
  endfunction

  // Offset of the instruction following the current one.
  function automatic word_t ret_off(input word_t off, input logic [LEN_W-1:0] len);
    ret_off = off + word_t'(len);
  endfunction

endpackage

// File: rtl/seg_addr_gen.sv
module seg_addr_gen
  import seg_ip_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  word_t  cs,
  input  word_t  ip,
  output paddr_t fetch_addr
);

  assign fetch_addr = phys_addr(cs, ip);

  // The segment never reaches the low bits of the sum.
  p_low_bits_r1: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_addr[SEG_SHIFT-1:0] == ip[SEG_SHIFT-1:0]);

  // With a zero offset the address is the segment alone.
  p_zero_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (ip == '0) |-> (fetch_addr[PA_W-1:SEG_SHIFT] == cs));

endmodule

// File: rtl/seg_ptr_regs.sv
module seg_ptr_regs
  import seg_ip_pkg::*;
#(
  parameter word_t RST_CS = 16'hFFFF,
  parameter word_t RST_IP = 16'h0000
) (
  input  logic    clk,
  input  logic    rst_n,
  input  commit_t commit,
  input  logic    bad_mov,
  output word_t   cs_q,
  output word_t   ip_q,
  output logic    invalid_op
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cs_q       <= RST_CS;
      ip_q       <= RST_IP;
      invalid_op <= 1'b0;
    end else begin
      if (commit.cs_we) cs_q <= commit.cs_val;
      if (commit.ip_we) ip_q <= commit.ip_val;
      invalid_op <= bad_mov;
    end
  end

  // A refused segment move must not arrive together with a register write.
  p_mov_no_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    bad_mov |-> !(commit.cs_we || commit.ip_we));

  // While the exception is shown, both registers hold their previous value.
  p_mov_keeps_regs_r9: assert property (@(posedge clk) disable iff (!rst_n)
    invalid_op |-> ($stable(cs_q) && $stable(ip_q)));

endmodule

// File: rtl/seg_xfer_seq.sv
module seg_xfer_seq
  import seg_ip_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             op_valid,
  input  logic [OP_W-1:0]  op_code,
  input  logic [LEN_W-1:0] instr_len,
  input  word_t            tgt_ip,
  input  word_t            tgt_cs,
  input  logic [VEC_W-1:0] int_num,
  input  word_t            flags_in,
  input  word_t            cur_cs,
  input  word_t            cur_ip,
  output logic             busy,
  output logic             stk_req,
  output logic             stk_write,
  output word_t            stk_wdata,
  input  logic             stk_ack,
  input  word_t            stk_rdata,
  output logic             ivt_req,
  output paddr_t           ivt_addr,
  input  logic             ivt_ack,
  input  word_t            ivt_rdata,
  output commit_t          commit,
  output logic             bad_mov,
  output logic             flags_valid,
  output word_t            flags_data
);

  step_e            step_q, step_d;
  op_e              kind_q;
  word_t            tcs_q, tip_q, ret_q, flg_q, tmp_q, tmp_d;
  logic [VEC_W-1:0] vec_q;

  op_e   op;
  logic  accept;
  word_t ret_now;
  logic  stk_done;
  logic  ivt_done;

  assign op       = op_e'(op_code);
  assign busy     = (step_q != ST_IDLE);
  assign accept   = op_valid && !busy;
  assign ret_now  = ret_off(cur_ip, instr_len);
  assign stk_done = stk_req && stk_ack;
  assign ivt_done = ivt_req && ivt_ack;

  always_comb begin
    step_d      = step_q;
    tmp_d       = tmp_q;
    commit      = '0;
    bad_mov     = 1'b0;
    stk_req     = 1'b0;
    stk_write   = 1'b0;
    stk_wdata   = '0;
    ivt_req     = 1'b0;
    ivt_addr    = '0;
    flags_valid = 1'b0;
    flags_data  = stk_rdata;
    case (step_q)
      ST_IDLE: begin
        if (op_valid) begin
          case (op)
            OP_STEP: begin
              commit.ip_we  = 1'b1;
              commit.ip_val = ret_now;
            end
            OP_JMP_N: begin
              commit.ip_we  = 1'b1;
              commit.ip_val = tgt_ip;
            end
            OP_JMP_F: begin
              commit.ip_we  = 1'b1;
              commit.ip_val = tgt_ip;
              commit.cs_we  = 1'b1;
              commit.cs_val = tgt_cs;
            end
            OP_MOV_CS: bad_mov = 1'b1;
            OP_CALL_N: step_d = ST_PUSH_IP;
            OP_CALL_F: step_d = ST_PUSH_CS;
            OP_SWI:    step_d = ST_PUSH_FLG;
            OP_RET_N, OP_RET_F, OP_IRET: step_d = ST_POP_IP;
            default: ;
          endcase
        end
      end
      ST_PUSH_FLG: begin
        stk_req   = 1'b1;
        stk_write = 1'b1;
        stk_wdata = flg_q;
        if (stk_done) step_d = ST_PUSH_CS;
      end
      ST_PUSH_CS: begin
        stk_req   = 1'b1;
        stk_write = 1'b1;
        stk_wdata = cur_cs;
        if (stk_done) step_d = ST_PUSH_IP;
      end
      ST_PUSH_IP: begin
        stk_req   = 1'b1;
        stk_write = 1'b1;
        stk_wdata = ret_q;
        if (stk_done) begin
          if (kind_q == OP_SWI) begin
            step_d = ST_VEC_IP;
          end else begin
            commit.ip_we  = 1'b1;
            commit.ip_val = tip_q;
            commit.cs_we  = (kind_q == OP_CALL_F);
            commit.cs_val = tcs_q;
            step_d        = ST_IDLE;
          end
        end
      end
      ST_VEC_IP: begin
        ivt_req  = 1'b1;
        ivt_addr = vec_addr(vec_q, 1'b0);
        if (ivt_done) begin
          tmp_d  = ivt_rdata;
          step_d = ST_VEC_CS;
        end
      end
      ST_VEC_CS: begin
        ivt_req  = 1'b1;
        ivt_addr = vec_addr(vec_q, 1'b1);
        if (ivt_done) begin
          commit.cs_we  = 1'b1;
          commit.cs_val = ivt_rdata;
          commit.ip_we  = 1'b1;
          commit.ip_val = tmp_q;
          step_d        = ST_IDLE;
        end
      end
      ST_POP_IP: begin
        stk_req = 1'b1;
        if (stk_done) begin
          if (kind_q == OP_RET_N) begin
            commit.ip_we  = 1'b1;
            commit.ip_val = stk_rdata;
            step_d        = ST_IDLE;
          end else begin
            tmp_d  = stk_rdata;
            step_d = ST_POP_CS;
          end
        end
      end
      ST_POP_CS: begin
        stk_req = 1'b1;
        if (stk_done) begin
          commit.cs_we  = 1'b1;
          commit.cs_val = stk_rdata;
          commit.ip_we  = 1'b1;
          commit.ip_val = tmp_q;
          step_d        = (kind_q == OP_IRET) ? ST_POP_FLG : ST_IDLE;
        end
      end
      ST_POP_FLG: begin
        stk_req = 1'b1;
        if (stk_done) begin
          flags_valid = 1'b1;
          step_d      = ST_IDLE;
        end
      end
      default: step_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      step_q <= ST_IDLE;
      kind_q <= OP_NOP;
      tcs_q  <= '0;
      tip_q  <= '0;
      ret_q  <= '0;
      flg_q  <= '0;
      vec_q  <= '0;
      tmp_q  <= '0;
    end else begin
      step_q <= step_d;
      tmp_q  <= tmp_d;
      if (accept) begin
        kind_q <= op;
        tcs_q  <= tgt_cs;
        tip_q  <= tgt_ip;
        ret_q  <= ret_now;
        flg_q  <= flags_in;
        vec_q  <= int_num;
      end
    end
  end

  p_stk_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (stk_req && !stk_ack) |=> (stk_req && $stable(stk_write) && $stable(stk_wdata)));

  p_ivt_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (ivt_req && !ivt_ack) |=> (ivt_req && $stable(ivt_addr)));

  p_one_port_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(stk_req && ivt_req));

  p_req_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (stk_req || ivt_req) |-> busy);

  p_ignore_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && op_valid) |=> $stable(kind_q));

  p_step_cs_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && op == OP_STEP) |=> $stable(cur_cs));

  p_near_cs_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && op == OP_JMP_N) |=> $stable(cur_cs));

  p_vec_word_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ivt_req |-> (ivt_addr[0] == 1'b0));

endmodule

// File: rtl/seg_ip_unit.sv
module seg_ip_unit
  import seg_ip_pkg::*;
#(
  parameter logic [WORD_W-1:0] RST_CS = 16'hFFFF,
  parameter logic [WORD_W-1:0] RST_IP = 16'h0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [OP_W-1:0]   op_code,
  input  logic [LEN_W-1:0]  instr_len,
  input  logic [WORD_W-1:0] tgt_ip,
  input  logic [WORD_W-1:0] tgt_cs,
  input  logic [VEC_W-1:0]  int_num,
  input  logic [WORD_W-1:0] flags_in,
  output logic              stk_req,
  output logic              stk_write,
  output logic [WORD_W-1:0] stk_wdata,
  input  logic              stk_ack,
  input  logic [WORD_W-1:0] stk_rdata,
  output logic              ivt_req,
  output logic [PA_W-1:0]   ivt_addr,
  input  logic              ivt_ack,
  input  logic [WORD_W-1:0] ivt_rdata,
  output logic [WORD_W-1:0] cs_out,
  output logic [WORD_W-1:0] ip_out,
  output logic [PA_W-1:0]   fetch_addr,
  output logic              busy,
  output logic              invalid_op,
  output logic              flags_valid,
  output logic [WORD_W-1:0] flags_data
);

  commit_t commit;
  logic    bad_mov;

  seg_xfer_seq u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .op_valid    (op_valid),
    .op_code     (op_code),
    .instr_len   (instr_len),
    .tgt_ip      (tgt_ip),
    .tgt_cs      (tgt_cs),
    .int_num     (int_num),
    .flags_in    (flags_in),
    .cur_cs      (cs_out),
    .cur_ip      (ip_out),
    .busy        (busy),
    .stk_req     (stk_req),
    .stk_write   (stk_write),
    .stk_wdata   (stk_wdata),
    .stk_ack     (stk_ack),
    .stk_rdata   (stk_rdata),
    .ivt_req     (ivt_req),
    .ivt_addr    (ivt_addr),
    .ivt_ack     (ivt_ack),
    .ivt_rdata   (ivt_rdata),
    .commit      (commit),
    .bad_mov     (bad_mov),
    .flags_valid (flags_valid),
    .flags_data  (flags_data)
  );

  seg_ptr_regs #(
    .RST_CS (RST_CS),
    .RST_IP (RST_IP)
  ) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .commit     (commit),
    .bad_mov    (bad_mov),
    .cs_q       (cs_out),
    .ip_q       (ip_out),
    .invalid_op (invalid_op)
  );

  seg_addr_gen u_addr (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs         (cs_out),
    .ip         (ip_out),
    .fetch_addr (fetch_addr)
  );

  // Registers move only through commits: no commit, no change.
  p_cs_only_commit_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !commit.cs_we |=> $stable(cs_out));

endmodule

// File: tb/seg_ip_unit_tb_top.sv
module seg_ip_unit_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        op_valid;
  logic [3:0]  op_code;
  logic [3:0]  instr_len;
  logic [15:0] tgt_ip, tgt_cs;
  logic [7:0]  int_num;
  logic [15:0] flags_in;
  logic        stk_req, stk_write, stk_ack;
  logic [15:0] stk_wdata, stk_rdata;
  logic        ivt_req, ivt_ack;
  logic [19:0] ivt_addr;
  logic [15:0] ivt_rdata;
  logic [15:0] cs_out, ip_out;
  logic [19:0] fetch_addr;
  logic        busy, invalid_op, flags_valid;
  logic [15:0] flags_data;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int stk_delay = 0;
  int ivt_delay = 1;
  int stk_wait = 0;
  int ivt_wait = 0;
  bit run_fetch = 0;
  logic [16:0] hold_word;
  logic [15:0] got_flags;
  logic [15:0] stack[$];
  logic [19:0] ivt_log[$];

  // 125 MHz: half period of 4 time units (ns).
  always #4 clk = ~clk;

  seg_ip_unit dut_i (
    .clk (clk), .rst_n (rst_n), .op_valid (op_valid), .op_code (op_code),
    .instr_len (instr_len), .tgt_ip (tgt_ip), .tgt_cs (tgt_cs),
    .int_num (int_num), .flags_in (flags_in),
    .stk_req (stk_req), .stk_write (stk_write), .stk_wdata (stk_wdata),
    .stk_ack (stk_ack), .stk_rdata (stk_rdata),
    .ivt_req (ivt_req), .ivt_addr (ivt_addr), .ivt_ack (ivt_ack), .ivt_rdata (ivt_rdata),
    .cs_out (cs_out), .ip_out (ip_out), .fetch_addr (fetch_addr),
    .busy (busy), .invalid_op (invalid_op),
    .flags_valid (flags_valid), .flags_data (flags_data)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] ivt_word(input logic [19:0] a);
    int v;
    v = (int'(a) * 7) % 65536;
    return 16'(v) ^ 16'h5A00;
  endfunction

  // Reference fetch address: integer arithmetic, 1 MiB wrap.
  function automatic logic [19:0] ref_fetch(input logic [15:0] s, input logic [15:0] o);
    int v;
    v = (int'(s) * 16 + int'(o)) % 1048576;
    return 20'(v);
  endfunction

  // Stack responder: acknowledges after stk_delay waiting cycles.
  always @(negedge clk) begin
    if (!rst_n) begin
      stk_ack  = 1'b0;
      stk_wait = 0;
    end else if (stk_ack) begin
      stk_ack = 1'b0;
    end else if (stk_req) begin
      if (stk_wait == 0) hold_word = {stk_write, stk_wdata};
      else chk("R11 stack request held", {15'd0, stk_write, stk_wdata}, {15'd0, hold_word});
      if (stk_wait >= stk_delay) begin
        stk_wait = 0;
        if (stk_write) stack.push_back(stk_wdata);
        else stk_rdata = (stack.size() > 0) ? stack.pop_back() : 16'hDEAD;
        stk_ack = 1'b1;
      end else begin
        stk_wait++;
      end
    end
  end

  // Vector table responder.
  always @(negedge clk) begin
    if (!rst_n) begin
      ivt_ack  = 1'b0;
      ivt_wait = 0;
    end else if (ivt_ack) begin
      ivt_ack = 1'b0;
    end else if (ivt_req) begin
      if (ivt_wait >= ivt_delay) begin
        ivt_wait = 0;
        ivt_log.push_back(ivt_addr);
        ivt_rdata = ivt_word(ivt_addr);
        ivt_ack = 1'b1;
      end else begin
        ivt_wait++;
      end
    end
  end

  always @(posedge clk) if (flags_valid) got_flags <= flags_data;

  // Every cycle: the fetch address matches the reference sum (R1).
  always @(negedge clk) begin
    if (rst_n && run_fetch)
      chk("R1 fetch sum", {12'd0, fetch_addr}, {12'd0, ref_fetch(cs_out, ip_out)});
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      errors++;
      $display("FAIL R10 watchdog actual=busy expected=idle");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic do_op(input int code, input int len, input logic [15:0] tip,
                       input logic [15:0] tcs, input logic [7:0] n, input logic [15:0] fl);
    @(negedge clk);
    op_valid  = 1'b1;
    op_code   = 4'(code);
    instr_len = 4'(len);
    tgt_ip    = tip;
    tgt_cs    = tcs;
    int_num   = n;
    flags_in  = fl;
    @(negedge clk);
    op_valid = 1'b0;
    while (busy) @(negedge clk);
  endtask

  initial begin
    int sz;
    rst_n = 1'b0; op_valid = 1'b0; op_code = '0; instr_len = '0;
    tgt_ip = '0; tgt_cs = '0; int_num = '0; flags_in = '0;
    stk_rdata = '0; ivt_rdata = '0; stk_ack = 1'b0; ivt_ack = 1'b0;
    got_flags = '0; hold_word = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R12 reset cs", {16'd0, cs_out}, 32'h0000FFFF);
    chk("R12 reset ip", {16'd0, ip_out}, 32'h0);
    chk("R12 reset fetch", {12'd0, fetch_addr}, 32'h000FFFF0);
    chk("R12 reset busy", {31'd0, busy}, 32'h0);
    chk("R12 reset invalid", {31'd0, invalid_op}, 32'h0);
    run_fetch = 1;

    do_op(3, 0, 16'h5678, 16'h1234, 8'h0, 16'h0);
    chk("R4 far jump cs", {16'd0, cs_out}, 32'h1234);
    chk("R4 far jump ip", {16'd0, ip_out}, 32'h5678);
    chk("R1 example address", {12'd0, fetch_addr}, 32'h179B8);

    do_op(1, 3, 16'h0, 16'h0, 8'h0, 16'h0);
    chk("R2 step ip", {16'd0, ip_out}, 32'h567B);
    chk("R2 step cs", {16'd0, cs_out}, 32'h1234);

    do_op(3, 0, 16'hFFFF, 16'hFFFF, 8'h0, 16'h0);
    chk("R1 wrap address", {12'd0, fetch_addr}, 32'h0FFEF);

    do_op(1, 2, 16'h0, 16'h0, 8'h0, 16'h0);
    chk("R2 step ip wrap", {16'd0, ip_out}, 32'h0001);
    chk("R2 step wrap fetch", {12'd0, fetch_addr}, 32'hFFFF1);

    do_op(2, 0, 16'h0100, 16'hABCD, 8'h0, 16'h0);
    chk("R3 near jump ip", {16'd0, ip_out}, 32'h0100);
    chk("R3 near jump cs", {16'd0, cs_out}, 32'hFFFF);

    do_op(3, 0, 16'h0010, 16'h2000, 8'h0, 16'h0);
    sz = stack.size();

    stk_delay = 0;
    do_op(4, 3, 16'h0400, 16'h9999, 8'h0, 16'h0);
    chk("R5 near call ip", {16'd0, ip_out}, 32'h0400);
    chk("R5 near call cs", {16'd0, cs_out}, 32'h2000);
    chk("R5 near call depth", stack.size(), sz + 1);
    chk("R5 near call saved", {16'd0, stack[$]}, 32'h0013);

    do_op(5, 0, 16'h0, 16'h0, 8'h0, 16'h0);
    chk("R5 near return ip", {16'd0, ip_out}, 32'h0013);
    chk("R5 near return depth", stack.size(), sz);

    stk_delay = 1;
    do_op(6, 5, 16'h0040, 16'h3000, 8'h0, 16'h0);
    chk("R6 far call cs", {16'd0, cs_out}, 32'h3000);
    chk("R6 far call ip", {16'd0, ip_out}, 32'h0040);
    chk("R6 far call depth", stack.size(), sz + 2);
    chk("R6 far call seg pushed first", {16'd0, stack[$-1]}, 32'h2000);
    chk("R6 far call offset on top", {16'd0, stack[$]}, 32'h0018);

    do_op(10, 0, 16'h1111, 16'h5555, 8'h0, 16'h0);
    chk("R9 invalid pulse", {31'd0, invalid_op}, 32'h1);
    chk("R9 cs kept", {16'd0, cs_out}, 32'h3000);
    chk("R9 ip kept", {16'd0, ip_out}, 32'h0040);
    @(negedge clk);
    chk("R9 pulse one cycle", {31'd0, invalid_op}, 32'h0);

    ivt_log.delete();
    do_op(8, 2, 16'h0, 16'h0, 8'h21, 16'h0246);
    chk("R7 int depth", stack.size(), sz + 5);
    chk("R7 flags pushed", {16'd0, stack[$-2]}, 32'h0246);
    chk("R7 seg pushed", {16'd0, stack[$-1]}, 32'h3000);
    chk("R7 offset pushed", {16'd0, stack[$]}, 32'h0042);
    chk("R7 vector reads", ivt_log.size(), 2);
    if (ivt_log.size() == 2) begin
      chk("R7 first vector addr", {12'd0, ivt_log[0]}, 32'h84);
      chk("R7 second vector addr", {12'd0, ivt_log[1]}, 32'h86);
    end
    chk("R7 new ip", {16'd0, ip_out}, {16'd0, ivt_word(20'h84)});
    chk("R7 new cs", {16'd0, cs_out}, {16'd0, ivt_word(20'h86)});

    do_op(9, 0, 16'h0, 16'h0, 8'h0, 16'h0);
    chk("R8 iret cs", {16'd0, cs_out}, 32'h3000);
    chk("R8 iret ip", {16'd0, ip_out}, 32'h0042);
    chk("R8 iret flags", {16'd0, got_flags}, 32'h0246);
    chk("R8 iret depth", stack.size(), sz + 2);

    do_op(7, 0, 16'h0, 16'h0, 8'h0, 16'h0);
    chk("R6 far return cs", {16'd0, cs_out}, 32'h2000);
    chk("R6 far return ip", {16'd0, ip_out}, 32'h0018);
    chk("R6 far return depth", stack.size(), sz);

    // Requests during a slow far call must be ignored.
    stk_delay = 3;
    @(negedge clk);
    op_valid = 1'b1; op_code = 4'd6; instr_len = 4'd4;
    tgt_ip = 16'h0200; tgt_cs = 16'h4000;
    @(negedge clk);
    op_code = 4'd3; tgt_ip = 16'h7777; tgt_cs = 16'h7777;
    chk("R10 busy after accept", {31'd0, busy}, 32'h1);
    @(negedge clk);
    chk("R10 busy held", {31'd0, busy}, 32'h1);
    @(negedge clk);
    op_valid = 1'b0;
    while (busy) @(negedge clk);
    chk("R10 ignored request cs", {16'd0, cs_out}, 32'h4000);
    chk("R10 ignored request ip", {16'd0, ip_out}, 32'h0200);
    chk("R6 slow call offset on top", {16'd0, stack[$]}, 32'h001C);
    chk("R6 slow call seg below", {16'd0, stack[$-1]}, 32'h2000);

    do_op(7, 0, 16'h0, 16'h0, 8'h0, 16'h0);
    chk("R6 slow return cs", {16'd0, cs_out}, 32'h2000);
    chk("R6 slow return ip", {16'd0, ip_out}, 32'h001C);
    chk("R10 idle after sequence", {31'd0, busy}, 32'h0);

    repeat (2) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule